// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block turns a set of I/O interrupt inputs into interrupt messages. Each input pin owns one redirection entry. The entry sets the vector, the delivery mode, the input polarity, edge or level detection, a mask, and a 16-bit destination. The destination carries the processor ID in its upper byte and the extended ID in its lower byte. Several level sources may share one pin. Each source is corrected for polarity before the sources are ORed together.

Software reaches the table through an indirect window. A write with `win_sel` low loads the index register. With `win_sel` high, writes and reads go to the location that the index selects.

- Index 0 is a read-only identification word. It holds the version in bits 7:0 and the highest pin number in bits 23:16. All other bits read as zero.
- Index 0x10+2n is the low word of entry n. Bit positions: vector 7:0, delivery mode 10:8, active-low polarity 13, remote-pending 14 (read-only), level trigger 15, mask 16.
- Index 0x11+2n is the high word of entry n. Its destination sits in bits 31:16.

A high-word write is only staged. The entry takes the new destination when its low word is written.

Pending requests go through a fixed-priority arbiter. The block sends one message at a time on a valid/ready port. After a level-triggered message is accepted, that entry stays blocked until an end-of-interrupt carrying its vector arrives on the EOI port. One such EOI releases every entry programmed with that vector.

Top module: `irt_ctrl`

## Requirements
- R1: Index 0 reads 0x00VV0021-style: version 0x21 in bits 7:0, NUM_PINS-1 in bits 23:16, zeros elsewhere. Writes to index 0 leave it unchanged.
- R2: After reset, no message is valid and every entry's low word reads 0x00010000 (masked, everything else zero).
- R3: Writing only the high word of an entry does not change the destination used in messages. The staged destination takes effect at the next write of that entry's low word.
- R4: An edge-triggered, unmasked entry sends exactly one message per inactive-to-active transition of its input. Holding the input active or releasing it sends nothing more.
- R5: An edge that occurs while the entry's mask bit (bit 16) is set is discarded. Clearing the mask afterwards produces no message.
- R6: Bit 13 set means active-low. A source held at its inactive level produces no message for either polarity.
- R7: When a level-triggered message is accepted (msg_valid and msg_ready both high), the entry's remote-pending bit (bit 14) reads 1. No further message comes from that entry while the bit is set, even if the input stays active.
- R8: An EOI clears remote-pending on every entry whose vector equals `eoi_vector`. An EOI with any other vector has no effect. An entry whose input is still active then sends a new message.
- R9: For a pin, the level seen is the OR over its SRCS_PER_PIN sources after polarity correction. Any one source alone can trigger the pin.
- R10: When several entries request at once, the lowest-numbered pin is sent first. While msg_valid is high and msg_ready is low, all message fields stay stable.
- R11: A message carries the entry's vector, 3-bit delivery mode (passed through unchanged; fixed=0, lowest-priority=1, PMI=2, INIT=5), destination, and trigger mode (msg_level=1 for level).
- R12: An index that names neither index 0 nor an entry reads as zero in the data window, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NUM_PINS*SRCS_PER_PIN | Interrupt sources; source s of pin p is bit p*SRCS_PER_PIN+s |
| win_we | input | 1 | Window write strobe |
| win_sel | input | 1 | 0 selects the index register, 1 the data window |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data for the current selection |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_level | output | 1 | 1 if the message came from a level-triggered entry |
| msg_dest | output | 16 | Message destination |

## Verification
The bench targets the corners where a careless design would deliver the wrong message.

- **Masked edges.** It fires an edge while the entry is masked, then unmasks it. A design that latches masked edges would send a stale message at that point.
- **Held level inputs.** It holds a level input active after acceptance. A design without the remote-pending block would flood the output with repeats.
- **EOI matching.** It sends an EOI with an unrelated vector, which must release nothing. It then sends a shared-vector EOI, which must release both sharers. A design comparing the wrong field would either stay stuck or release the wrong entry.
- **Staged destination.** It writes only a high word and checks the message still uses the old destination.
- **Simultaneous requests.** It raises two pins together and stalls the consumer. Wrong priority shows up as a different vector first; an unstable holding register shows up as fields changing during the stall.

// File: rtl/irt_pkg.sv
package irt_pkg;

   localparam int VEC_W  = 8;
   localparam int DEST_W = 16;

   // delivery mode encodings carried through unchanged
   localparam logic [2:0] DM_FIXED  = 3'd0;
   localparam logic [2:0] DM_LOWEST = 3'd1;
   localparam logic [2:0] DM_PMI    = 3'd2;
   localparam logic [2:0] DM_INIT   = 3'd5;

   // low word bit positions
   localparam int LO_POL_BIT  = 13;
   localparam int LO_RPND_BIT = 14;
   localparam int LO_LVL_BIT  = 15;
   localparam int LO_MASK_BIT = 16;

   typedef struct packed {
      logic [VEC_W-1:0]  vector;
      logic [2:0]        dmode;
      logic              pol;
      logic              level;
      logic              mask;
      logic [DEST_W-1:0] dest;
   } rte_t;

   localparam rte_t RTE_RESET = '{vector: '0, dmode: 3'd0, pol: 1'b0,
                                  level: 1'b0, mask: 1'b1, dest: '0};

endpackage

// File: rtl/irt_table.sv
module irt_table #(
   parameter int         NUM_PINS = 8,
   parameter logic [7:0] VERSION  = 8'h21
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                win_we,
   input  logic                win_sel,
   input  logic [31:0]         win_wdata,
   input  logic [NUM_PINS-1:0] remote_i,
   output logic [31:0]         win_rdata,
   output irt_pkg::rte_t       cfg_o [NUM_PINS]
);
   import irt_pkg::*;

   localparam int ENT_BASE = 16;
   localparam int ENT_LAST = ENT_BASE + 2*NUM_PINS - 1;
   localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

   generate
      if (NUM_PINS < 1 || ENT_LAST > 255) begin : g_bad_cfg
         $error("irt_table: NUM_PINS does not fit the 8-bit index space");
      end
   endgenerate

   logic [7:0]        idx_q;
   logic [7:0]        rel;
   logic              in_tab;
   logic              data_we;
   rte_t              ent_q    [NUM_PINS];
   logic [DEST_W-1:0] shadow_q [NUM_PINS];

   assign in_tab  = (int'(idx_q) >= ENT_BASE) && (int'(idx_q) <= ENT_LAST);
   assign rel     = idx_q - 8'(ENT_BASE);
   assign data_we = win_we & win_sel & in_tab;

   logic unused_bits;
   assign unused_bits = ^{win_wdata[12:11], win_wdata[LO_RPND_BIT]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < NUM_PINS; i++) begin
            ent_q[i]    <= RTE_RESET;
            shadow_q[i] <= '0;
         end
      end else begin
         if (win_we && !win_sel)
            idx_q <= win_wdata[7:0];
         for (int i = 0; i < NUM_PINS; i++) begin
            if (data_we && rel[7:1] == 7'(i)) begin
               if (rel[0]) begin
                  shadow_q[i] <= win_wdata[31:16];
               end else begin
                  ent_q[i].vector <= win_wdata[7:0];
                  ent_q[i].dmode  <= win_wdata[10:8];
                  ent_q[i].pol    <= win_wdata[LO_POL_BIT];
                  ent_q[i].level  <= win_wdata[LO_LVL_BIT];
                  ent_q[i].mask   <= win_wdata[LO_MASK_BIT];
                  ent_q[i].dest   <= shadow_q[i];
               end
            end
         end
      end
   end

   always_comb begin
      win_rdata = '0;
      if (!win_sel) begin
         win_rdata = {24'h0, idx_q};
      end else if (idx_q == 8'h00) begin
         win_rdata = {8'h00, MAX_PIN, 8'h00, VERSION};
      end else begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (in_tab && rel[7:1] == 7'(i)) begin
               if (rel[0])
                  win_rdata = {shadow_q[i], 16'h0};
               else
                  win_rdata = {15'h0, ent_q[i].mask, ent_q[i].level,
                               remote_i[i], ent_q[i].pol, 2'b00,
                               ent_q[i].dmode, ent_q[i].vector};
            end
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < NUM_PINS; g++) begin : g_ent
         logic hi_we;
         assign hi_we = data_we & rel[0] & (rel[7:1] == 7'(g));
         assign cfg_o[g] = ent_q[g];

         // R3
         hi_stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hi_we |=> $stable(ent_q[g].dest));
      end
   endgenerate

endmodule

// File: rtl/irt_src_unit.sv
module irt_src_unit #(
   parameter int SRCS        = 2,
   parameter int SYNC_STAGES = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SRCS-1:0] src_i,
   input  logic            pol_i,
   input  logic            level_i,
   input  logic            mask_i,
   input  logic            load_i,
   input  logic            accept_i,
   input  logic            eoi_hit_i,
   output logic            req_o,
   output logic            remote_o
);

   generate
      if (SRCS < 1 || SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_cfg
         $error("irt_src_unit: SRCS >= 1 and SYNC_STAGES of 1 or 2 required");
      end
   endgenerate

   logic [SRCS-1:0] smp;

   generate
      if (SYNC_STAGES == 2) begin : g_two
         logic [SRCS-1:0] s1_q, s2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1_q <= '0;
               s2_q <= '0;
            end else begin
               s1_q <= src_i;
               s2_q <= s1_q;
            end
         end
         assign smp = s2_q;
      end else begin : g_one
         logic [SRCS-1:0] s1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s1_q <= '0;
            else        s1_q <= src_i;
         end
         assign smp = s1_q;
      end
   endgenerate

   logic lvl, lvl_q, pend_q, remote_q, rise_ok;

   assign lvl     = |(smp ^ {SRCS{pol_i}});
   assign rise_ok = lvl & ~lvl_q & ~mask_i & ~level_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= 1'b0;
         pend_q   <= 1'b0;
         remote_q <= 1'b0;
      end else begin
         lvl_q  <= lvl;
         pend_q <= (pend_q & ~load_i) | rise_ok;
         if (accept_i && level_i)
            remote_q <= 1'b1;
         else if (eoi_hit_i)
            remote_q <= 1'b0;
      end
   end

   assign req_o    = level_i ? (lvl & ~mask_i & ~remote_q) : (pend_q & ~mask_i);
   assign remote_o = remote_q;

   // R5
   masked_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_i |=> !$rose(pend_q));

   // R7
   remote_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote_q) |-> $past(accept_i));

   // R7
   remote_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (remote_q && level_i) |-> !req_o);

endmodule

// File: rtl/irt_prio_arb.sv
module irt_prio_arb #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] gnt_o
);

   always_comb begin
      any_o = 1'b0;
      gnt_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            gnt_o = IW'(i);
         end
      end
   end

endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl #(
   parameter int         NUM_PINS     = 8,
   parameter int         SRCS_PER_PIN = 2,
   parameter int         SYNC_STAGES  = 1,
   parameter logic [7:0] VERSION      = 8'h21
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_PINS*SRCS_PER_PIN-1:0] irq_src,
   input  logic                             win_we,
   input  logic                             win_sel,
   input  logic [31:0]                      win_wdata,
   output logic [31:0]                      win_rdata,
   input  logic                             eoi_valid,
   input  logic [7:0]                       eoi_vector,
   output logic                             msg_valid,
   input  logic                             msg_ready,
   output logic [7:0]                       msg_vector,
   output logic [2:0]                       msg_dmode,
   output logic                             msg_level,
   output logic [15:0]                      msg_dest
);
   import irt_pkg::*;

   localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   rte_t                cfg [NUM_PINS];
   logic [NUM_PINS-1:0] req, remote, load_v, accept_v;
   logic                any, load, accept;
   logic [IW-1:0]       gnt, cur_q;
   logic                valid_q;
   rte_t                out_q;

   irt_table #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_table (
      .clk, .rst_n, .win_we, .win_sel, .win_wdata,
      .remote_i(remote), .win_rdata, .cfg_o(cfg));

   genvar g;
   generate
      for (g = 0; g < NUM_PINS; g++) begin : g_pin
         assign load_v[g]   = load   && (gnt   == IW'(g));
         assign accept_v[g] = accept && (cur_q == IW'(g));
         irt_src_unit #(.SRCS(SRCS_PER_PIN), .SYNC_STAGES(SYNC_STAGES)) u_src (
            .clk, .rst_n,
            .src_i(irq_src[g*SRCS_PER_PIN +: SRCS_PER_PIN]),
            .pol_i(cfg[g].pol), .level_i(cfg[g].level), .mask_i(cfg[g].mask),
            .load_i(load_v[g]), .accept_i(accept_v[g]),
            .eoi_hit_i(eoi_valid && (cfg[g].vector == eoi_vector)),
            .req_o(req[g]), .remote_o(remote[g]));
      end
   endgenerate

   irt_prio_arb #(.N(NUM_PINS), .IW(IW)) u_arb (
      .req_i(req), .any_o(any), .gnt_o(gnt));

   assign load   = !valid_q && any;
   assign accept = valid_q && msg_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         cur_q   <= '0;
         out_q   <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         cur_q   <= gnt;
         out_q   <= cfg[gnt];
      end else if (accept) begin
         valid_q <= 1'b0;
      end
   end

   assign msg_valid  = valid_q;
   assign msg_vector = out_q.vector;
   assign msg_dmode  = out_q.dmode;
   assign msg_level  = out_q.level;
   assign msg_dest   = out_q.dest;

   logic unused_out;
   assign unused_out = ^{out_q.pol, out_q.mask};

   logic [NUM_PINS-1:0] below;
   assign below = ~({NUM_PINS{1'b1}} << gnt);

   // R10
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
                                     $stable(msg_dest) && $stable(msg_dmode)));

   // R10
   lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> ((req & below) == '0));

endmodule

// File: tb/irt_ctrl_test.sv
module irt_ctrl_test;

   localparam int NP = 8;
   localparam int NS = 2;

   typedef struct packed {
      logic [3:0]  pin;
      logic [7:0]  vec;
      logic [2:0]  dm;
      logic        pol;
      logic [15:0] dest;
   } row_t;

   localparam row_t ROWS [4] = '{
      '{pin: 4'd0, vec: 8'h31, dm: 3'd0, pol: 1'b0, dest: 16'h0102},
      '{pin: 4'd2, vec: 8'h42, dm: 3'd1, pol: 1'b0, dest: 16'h0304},
      '{pin: 4'd5, vec: 8'h73, dm: 3'd2, pol: 1'b1, dest: 16'hA5B6},
      '{pin: 4'd7, vec: 8'h9C, dm: 3'd5, pol: 1'b1, dest: 16'hFF00}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n;
   logic [NP*NS-1:0] irq_src;
   logic             win_we, win_sel;
   logic [31:0]      win_wdata, win_rdata;
   logic             eoi_valid;
   logic [7:0]       eoi_vector;
   logic             msg_valid, msg_ready, msg_level;
   logic [7:0]       msg_vector;
   logic [2:0]       msg_dmode;
   logic [15:0]      msg_dest;

   irt_ctrl #(.NUM_PINS(NP), .SRCS_PER_PIN(NS)) uut (
      .clk, .rst_n, .irq_src, .win_we, .win_sel, .win_wdata, .win_rdata,
      .eoi_valid, .eoi_vector, .msg_valid, .msg_ready, .msg_vector,
      .msg_dmode, .msg_level, .msg_dest);

   int total = 0;
   int failed = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp_v);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   function automatic logic [31:0] lowword(input logic [7:0] v, input logic [2:0] d,
                                           input logic pol, input logic lvl,
                                           input logic msk);
      return {15'h0, msk, lvl, 1'b0, pol, 2'b00, d, v};
   endfunction

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      win_sel = sel; win_wdata = d; win_we = 1'b1;
      @(negedge clk);
      win_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] idx, output logic [31:0] d);
      wr(1'b0, {24'h0, idx});
      win_sel = 1'b1;
      #1 d = win_rdata;
   endtask

   task automatic prog(input int p, input logic [31:0] lo, input logic [31:0] hi);
      wr(1'b0, 32'(16 + 2*p + 1));
      wr(1'b1, hi);
      wr(1'b0, 32'(16 + 2*p));
      wr(1'b1, lo);
   endtask

   task automatic wait_msg(output bit got);
      got = 1'b0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (msg_valid) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   task automatic quiet(input int n, output bit ok);
      ok = 1'b1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (msg_valid) ok = 1'b0;
      end
   endtask

   task automatic take();
      @(negedge clk);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic eoi(input logic [7:0] v);
      @(negedge clk);
      eoi_valid = 1'b1; eoi_vector = v;
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++; failed++;
      $display("FAIL watchdog expired (all requirements) actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      logic [31:0] d;
      bit got, ok;
      int p;
      rst_n = 1'b0; irq_src = '0; win_we = 1'b0; win_sel = 1'b0; win_wdata = '0;
      eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      chk(msg_valid == 1'b0, "R2 no message after reset", 32'(msg_valid), 0);
      rd(8'h16, d);
      chk(d == 32'h0001_0000, "R2 pin3 low word masked", d, 32'h0001_0000);
      // R1 identification word
      rd(8'h00, d);
      chk(d == 32'h0007_0021, "R1 version word", d, 32'h0007_0021);

      // table walk: R4 R6 R11
      for (int i = 0; i < 4; i++) begin
         p = int'(ROWS[i].pin);
         @(negedge clk);
         irq_src[2*p] = ROWS[i].pol; irq_src[2*p+1] = ROWS[i].pol;
         prog(p, lowword(ROWS[i].vec, ROWS[i].dm, ROWS[i].pol, 1'b0, 1'b0),
              {ROWS[i].dest, 16'h0});
         quiet(4, ok);
         chk(ok, "R6 idle level gives no message", 32'(!ok), 0);
         irq_src[2*p] = ~ROWS[i].pol;
         wait_msg(got);
         chk(got, "R4 edge produces message", 32'(got), 1);
         chk(msg_vector == ROWS[i].vec, "R11 vector", 32'(msg_vector), 32'(ROWS[i].vec));
         chk(msg_dmode == ROWS[i].dm, "R11 delivery mode", 32'(msg_dmode), 32'(ROWS[i].dm));
         chk(msg_dest == ROWS[i].dest, "R11 destination", 32'(msg_dest), 32'(ROWS[i].dest));
         chk(msg_level == 1'b0, "R11 trigger mode", 32'(msg_level), 0);
         take();
         quiet(6, ok);
         chk(ok, "R4 held input sends once", 32'(!ok), 0);
         irq_src[2*p] = ROWS[i].pol;
         quiet(4, ok);
         chk(ok, "R4 release sends nothing", 32'(!ok), 0);
      end

      // R5 masked edge dropped
      prog(1, lowword(8'h21, 3'd0, 1'b0, 1'b0, 1'b1), 32'h1111_0000);
      @(negedge clk); irq_src[2] = 1'b1;
      quiet(5, ok);
      chk(ok, "R5 masked edge no message", 32'(!ok), 0);
      @(negedge clk); irq_src[2] = 1'b0;
      wr(1'b0, 32'h12);
      wr(1'b1, lowword(8'h21, 3'd0, 1'b0, 1'b0, 1'b0));
      quiet(6, ok);
      chk(ok, "R5 unmask gives no stale message", 32'(!ok), 0);

      // R3 staged destination
      wr(1'b0, 32'h13);
      wr(1'b1, 32'h2222_0000);
      @(negedge clk); irq_src[2] = 1'b1;
      wait_msg(got);
      chk(got && msg_dest == 16'h1111, "R3 high write alone not active", 32'(msg_dest), 32'h1111);
      take();
      @(negedge clk); irq_src[2] = 1'b0;
      wr(1'b0, 32'h12);
      wr(1'b1, lowword(8'h21, 3'd0, 1'b0, 1'b0, 1'b0));
      @(negedge clk); irq_src[2] = 1'b1;
      wait_msg(got);
      chk(got && msg_dest == 16'h2222, "R3 low write commits", 32'(msg_dest), 32'h2222);
      take();
      @(negedge clk); irq_src[2] = 1'b0;

      // R7 R8 level entries sharing vector 0x55
      prog(3, lowword(8'h55, 3'd1, 1'b0, 1'b1, 1'b0), 32'h0303_0000);
      prog(4, lowword(8'h55, 3'd1, 1'b0, 1'b1, 1'b0), 32'h0404_0000);
      @(negedge clk); irq_src[6] = 1'b1;
      wait_msg(got);
      chk(got && msg_dest == 16'h0303 && msg_level, "R7 level message pin3",
          32'(msg_dest), 32'h0303);
      take();
      quiet(6, ok);
      chk(ok, "R7 remote blocks redelivery", 32'(!ok), 0);
      rd(8'h16, d);
      chk(d[14] == 1'b1, "R7 remote bit set", d, d | 32'h4000);
      @(negedge clk); irq_src[8] = 1'b1;
      wait_msg(got);
      chk(got && msg_dest == 16'h0404, "R7 second sharer pin4", 32'(msg_dest), 32'h0404);
      take();
      eoi(8'h66);
      quiet(6, ok);
      chk(ok, "R8 unrelated EOI no effect", 32'(!ok), 0);
      @(negedge clk); irq_src[8] = 1'b0;
      eoi(8'h55);
      wait_msg(got);
      chk(got && msg_dest == 16'h0303, "R8 EOI rearms pin3", 32'(msg_dest), 32'h0303);
      rd(8'h18, d);
      chk(d[14] == 1'b0, "R8 EOI cleared pin4 remote", d, d & ~32'h4000);
      take();
      @(negedge clk); irq_src[6] = 1'b0;
      eoi(8'h55);

      // R9 second source of pin3
      @(negedge clk); irq_src[7] = 1'b1;
      wait_msg(got);
      chk(got && msg_dest == 16'h0303, "R9 other source triggers", 32'(msg_dest), 32'h0303);
      take();
      @(negedge clk); irq_src[7] = 1'b0;
      eoi(8'h55);
      quiet(4, ok);
      chk(ok, "R9 sources idle no message", 32'(!ok), 0);

      // R10 priority and hold
      @(negedge clk); irq_src[4] = 1'b1; irq_src[10] = 1'b0;
      wait_msg(got);
      chk(got && msg_vector == 8'h42, "R10 lowest pin first", 32'(msg_vector), 32'h42);
      repeat (3) @(negedge clk);
      chk(msg_valid && msg_vector == 8'h42 && msg_dest == 16'h0304, "R10 stable while stalled",
          32'(msg_vector), 32'h42);
      take();
      wait_msg(got);
      chk(got && msg_vector == 8'h73, "R10 next pin follows", 32'(msg_vector), 32'h73);
      take();
      @(negedge clk); irq_src[4] = 1'b0; irq_src[10] = 1'b1;

      // R12 unused index
      wr(1'b0, 32'h70);
      wr(1'b1, 32'hFFFF_FFFF);
      rd(8'h70, d);
      chk(d == 32'h0, "R12 unused index reads zero", d, 0);
      // R1 version is read-only
      wr(1'b0, 32'h00);
      wr(1'b1, 32'hDEAD_BEEF);
      rd(8'h00, d);
      chk(d == 32'h0007_0021, "R1 version not writable", d, 32'h0007_0021);
      quiet(4, ok);
      chk(ok, "R12 stray write no message", 32'(!ok), 0);

      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule